// File: doc/BRIEF.md
# Banked GPIO Edge-Detect Interrupt Unit

This block watches a parameterised set of general-purpose input pins (121 by default) and turns selected transitions on them into interrupt requests. Every pin first crosses into the local clock domain through a two-flop synchronizer. A transition is found by comparing the synchronized level with its value one clock earlier. Each pin has its own rising-enable and falling-enable bit. When a transition matches an enable, the pin's sticky status bit is set and stays set until software clears it by writing a 1 to it.

The pins are grouped into banks of 32. Bank `b` holds pins `32*b` to `32*b+31`, and a pin's bit sits at position `pin mod 32`. The last bank is shortened when the pin count is not a multiple of 32: 121 pins give banks of 32, 32, 32 and 25, and 81 pins give 32, 32 and 17. Pins 0 and 1 each drive a private interrupt line. Every other status bit is ORed into a single shared line. Software reaches the enables and status through a word-wide register port. Reads have one cycle of latency.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin whose rising-enable bit is 1 sets its status bit when its input goes from 0 to 1. The status bit is visible at the third rising clock edge after the input changes: two synchronizer stages, then the compare-and-record stage.
- R2: A pin whose falling-enable bit is 1 sets its status bit on a 1-to-0 transition. With only the falling enable set, a rising transition is not recorded. With both enables set, both directions are recorded.
- R3: A pin whose rising-enable and falling-enable bits are both 0 never sets its status bit, whatever its input does.
- R4: Writing a status word clears every status bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears the whole bank.
- R5: Bank `b` holds `min(32, NUM_PINS-32*b)` pins. Status and enable bits above the last pin of a bank cannot be set and always read as 0. With 121 pins, writing all ones to bank 3's rising-enable word reads back as 0x01FFFFFF.
- R6: `irq_pin0` is 1 exactly while bank 0 status bit 0 is set. `irq_pin1` is 1 exactly while bank 0 status bit 1 is set.
- R7: `irq_shared` is the OR of every status bit in every bank except bank 0 bits 0 and 1.
- R8: After a synchronous reset, all enable bits and all status bits read as 0 and all three interrupt outputs are 0.
- R9: The register port decodes the byte offset `addr`. Bits [5:4] select the group: 0 = status, 1 = rising enable, 2 = falling enable, 3 = unmapped. Bits [3:2] select the bank, and bits [1:0] are ignored. A read registers the selected word into `rdata` at the clock edge where `rd_en` is sampled, and it returns the value held before any write in that same cycle. Unmapped offsets and absent banks read as 0. `rdata` holds its value in cycles with no read.
- R10: If a transition is recorded in the same cycle that a write of 1 clears that status bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_shared | output | 1 | Combined interrupt for all other pins |

## Verification
Single pins are toggled under rising-only, falling-only, both and no enable. This separates the enable polarity of each direction and confirms that a disabled pin stays quiet. Pins are driven in the first, a middle and the shortened last bank, and at bits 0, 1 and 24 within a bank. This exposes bank and bit misplacement and shows whether pins 0 and 1 are wrongly routed to the shared line. One clear write is timed to land in the exact cycle of a new transition, which distinguishes set priority from clear priority. Writes of all ones and of zero to status and enable words show the write-1-to-clear rule and the zero bits above the last pin.

// File: rtl/gpio_edge_pkg.sv
// Package gpio_edge_pkg
// Shared constants, the register group encoding and the per-bank valid-bit mask.
// Assumes at most four banks of 32 pins, addressed by a 6-bit byte offset.
package gpio_edge_pkg;
    localparam int BANK_W = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        GRP_STAT = 2'd0,
        GRP_RISE = 2'd1,
        GRP_FALL = 2'd2,
        GRP_NONE = 2'd3
    } reg_grp_e;

    // Bits of bank 'bank' that map to a real pin when npins pins exist.
    function automatic logic [BANK_W-1:0] bank_mask(int npins, int bank);
        int n;
        n = npins - bank * BANK_W;
        if (n <= 0)
            return '0;
        else if (n >= BANK_W)
            return '1;
        else
            return (BANK_W'(1) << n) - BANK_W'(1);
    endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
// Module gpio_edge_sync
// Brings asynchronous pin levels into the clock domain through two flops each,
// keeps one further delayed copy and reports single-cycle rise and fall events.
// Assumes pins are quasi-static relative to the clock; no glitch filtering.
module gpio_edge_sync #(
    parameter int N = 121
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_in,
    output logic [N-1:0] rise_ev,
    output logic [N-1:0] fall_ev
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    // Synchronizer chain plus one-cycle history of the synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Level now differs from level one clock earlier.
    assign rise_ev = sync_q & ~prev_q;
    assign fall_ev = prev_q & ~sync_q;
endmodule

// File: rtl/gpio_edge_bank.sv
// Module gpio_edge_bank
// One bank of 32 pin slots: rising-enable, falling-enable and sticky status words.
// Status is write-1-to-clear; a new event in the same cycle as a clear wins.
// Assumes VALID_MASK marks the slots that map to real pins; others stay zero.
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] rise_ev,
    input  logic [BANK_W-1:0] fall_ev,
    input  logic              wr_stat,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] stat_q,
    output logic [BANK_W-1:0] rise_en_q,
    output logic [BANK_W-1:0] fall_en_q
);
    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] clr;

    // Events that match an enabled direction on a real pin.
    assign hit = ((rise_ev & rise_en_q) | (fall_ev & fall_en_q)) & VALID_MASK;
    assign clr = wr_stat ? wdata : '0;

    // Enable registers, masked to real pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else begin
            if (wr_rise) rise_en_q <= wdata & VALID_MASK;
            if (wr_fall) fall_en_q <= wdata & VALID_MASK;
        end
    end

    // Sticky status: clear requested ones, then set new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr) | hit) & VALID_MASK;
    end

    // R4: a bit written as 1 with no new hit is 0 afterwards.
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_q & $past(wdata & ~hit)) == '0));

    // R10: a hit is always present in the next status word, clear or not.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));

    // R3: a newly set status bit must have had an enable bit set.
    a_r3_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(rise_en_q | fall_en_q)) == '0));

    // R5: slots beyond the last pin never hold a 1.
    a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q | rise_en_q | fall_en_q) & ~VALID_MASK) == '0);
endmodule

// File: rtl/gpio_edge_irq.sv
// Module gpio_edge_irq
// Top of the edge-detect interrupt unit: synchronizers, one bank per 32 pins,
// register decode with one-cycle read latency, and the three interrupt lines.
// Assumes 3 <= NUM_PINS <= 128 (four banks at most, two private pins).
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 121
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_in,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]   wdata,
    output logic [BANK_W-1:0]   rdata,
    output logic                irq_pin0,
    output logic                irq_pin1,
    output logic                irq_shared
);
    localparam int BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int PAD_W = BANKS * BANK_W;

    logic [NUM_PINS-1:0] rise_ev, fall_ev;
    logic [PAD_W-1:0]    rise_all, fall_all, stat_flat;
    logic [BANK_W-1:0]   stat_w [BANKS];
    logic [BANK_W-1:0]   rise_w [BANKS];
    logic [BANK_W-1:0]   fall_w [BANKS];
    logic [BANK_W-1:0]   rd_word;
    reg_grp_e            grp;
    logic [1:0]          bank_sel;
    logic                unused_lsb;

    assign grp        = reg_grp_e'(addr[5:4]);
    assign bank_sel   = addr[3:2];
    assign unused_lsb = ^addr[1:0];

    gpio_edge_sync #(.N(NUM_PINS)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_in),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    // Widen event vectors to whole banks.
    always_comb begin
        rise_all = '0;
        fall_all = '0;
        rise_all[NUM_PINS-1:0] = rise_ev;
        fall_all[NUM_PINS-1:0] = fall_ev;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel;
        assign sel = wr_en && (int'(bank_sel) == b);

        gpio_edge_bank #(.VALID_MASK(bank_mask(NUM_PINS, b))) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_ev   (rise_all[b*BANK_W +: BANK_W]),
            .fall_ev   (fall_all[b*BANK_W +: BANK_W]),
            .wr_stat   (sel && grp == GRP_STAT),
            .wr_rise   (sel && grp == GRP_RISE),
            .wr_fall   (sel && grp == GRP_FALL),
            .wdata     (wdata),
            .stat_q    (stat_w[b]),
            .rise_en_q (rise_w[b]),
            .fall_en_q (fall_w[b])
        );

        assign stat_flat[b*BANK_W +: BANK_W] = stat_w[b];
    end

    // Select the addressed word; unmapped group or absent bank reads zero.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (int'(bank_sel) == b) begin
                case (grp)
                    GRP_STAT: rd_word = stat_w[b];
                    GRP_RISE: rd_word = rise_w[b];
                    GRP_FALL: rd_word = fall_w[b];
                    default:  rd_word = '0;
                endcase
            end
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    assign irq_pin0   = stat_flat[0];
    assign irq_pin1   = stat_flat[1];
    assign irq_shared = |stat_flat[PAD_W-1:2];

    // R9: read data only changes on a cycle that carried a read strobe.
    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == $past(rdata)));
endmodule

// File: tb/gpio_edge_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb_top;
    localparam int NP = 121;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins_in = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_pin0, irq_pin1, irq_shared;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_irq #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_shared(irq_shared)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0]   m_stat [4];
    logic [31:0]   m_rise [4];
    logic [31:0]   m_fall [4];
    logic [31:0]   m_rdata;
    logic [NP-1:0] hist [$];

    function automatic logic [31:0] valid_bits(int bank);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (bank * 32 + i) < NP;
        return m;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        int bk;
        bk = int'(a[3:2]);
        case (a[5:4])
            2'd0:    return m_stat[bk];
            2'd1:    return m_rise[bk];
            2'd2:    return m_fall[bk];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [127:0] rp, fp;
        logic [31:0]  hits, clr;
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                m_stat[b] = '0; m_rise[b] = '0; m_fall[b] = '0;
            end
            m_rdata = '0;
            hist.delete();
            repeat (3) hist.push_back('0);
        end else begin
            if (rd_en) m_rdata = m_read(addr);
            rp = '0; fp = '0;
            rp[NP-1:0] = hist[1] & ~hist[2];
            fp[NP-1:0] = ~hist[1] & hist[2];
            for (int b = 0; b < 4; b++) begin
                hits = ((rp[b*32 +: 32] & m_rise[b]) | (fp[b*32 +: 32] & m_fall[b])) & valid_bits(b);
                clr  = (wr_en && addr[5:4] == 2'd0 && int'(addr[3:2]) == b) ? wdata : 32'h0;
                m_stat[b] = (m_stat[b] & ~clr) | hits;
                if (wr_en && addr[5:4] == 2'd1 && int'(addr[3:2]) == b) m_rise[b] = wdata & valid_bits(b);
                if (wr_en && addr[5:4] == 2'd2 && int'(addr[3:2]) == b) m_fall[b] = wdata & valid_bits(b);
            end
            hist.push_front(pins_in);
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 irq_pin0", 32'(irq_pin0), 32'(m_stat[0][0]));
            check("R6 irq_pin1", 32'(irq_pin1), 32'(m_stat[0][1]));
            check("R7 irq_shared", 32'(irq_shared),
                  32'(|{m_stat[0][31:2], m_stat[1], m_stat[2], m_stat[3]}));
            check("R9 rdata", rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(string req, logic [5:0] a, logic [31:0] exp);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic pin(int p, logic v);
        @(negedge clk); pins_in[p] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state of all mapped words and interrupt lines.
        for (int a = 0; a < 12; a++) rd("R8 reset word", 6'(a * 4), 32'h0);
        check("R8 irq lines", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h0);

        // R9: unmapped group reads zero.
        rd("R9 unmapped", 6'h30, 32'h0);

        // R5: shortened last bank keeps only 25 enable bits.
        wr(6'h1C, 32'hFFFF_FFFF);
        rd("R5 bank3 rise mask", 6'h1C, 32'h01FF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        rd("R5 bank0 rise full", 6'h10, 32'hFFFF_FFFF);

        // R1: rising edge on pin 5 is recorded and raises the shared line.
        pin(5, 1'b1);
        rd("R1 pin5 rise", 6'h00, 32'h0000_0020);
        check("R7 shared from pin5", 32'(irq_shared), 32'h1);

        // R4: writing zero keeps, writing one clears.
        wr(6'h00, 32'h0);
        rd("R4 zero write keeps", 6'h00, 32'h0000_0020);
        wr(6'h00, 32'h0000_0020);
        rd("R4 one write clears", 6'h00, 32'h0);
        check("R4 shared low after clear", 32'(irq_shared), 32'h0);

        // R6: pin 0 drives its own line only.
        pin(0, 1'b1);
        check("R6 pin0 private line", {30'h0, irq_pin0, irq_shared}, 32'h2);
        pin(1, 1'b1);
        check("R6 pin1 private line", {30'h0, irq_pin1, irq_shared}, 32'h2);
        wr(6'h00, 32'hFFFF_FFFF);
        check("R6 lines cleared", {30'h0, irq_pin0, irq_pin1}, 32'h0);

        // R2: falling-only on pin 35 (bank1 bit3).
        wr(6'h24, 32'h0000_0008);
        pin(35, 1'b1);
        rd("R2 rise ignored when falling-only", 6'h04, 32'h0);
        pin(35, 1'b0);
        rd("R2 fall recorded", 6'h04, 32'h0000_0008);
        wr(6'h04, 32'hFFFF_FFFF);

        // R2: both directions on pin 71 (bank2 bit7).
        wr(6'h18, 32'h0000_0080);
        wr(6'h28, 32'h0000_0080);
        pin(71, 1'b1);
        rd("R2 both rise", 6'h08, 32'h0000_0080);
        wr(6'h08, 32'h0000_0080);
        pin(71, 1'b0);
        rd("R2 both fall", 6'h08, 32'h0000_0080);
        wr(6'h08, 32'hFFFF_FFFF);

        // R3: pin 100 (bank3 bit4) with both enables cleared.
        wr(6'h1C, 32'h0);
        pin(100, 1'b1);
        pin(100, 1'b0);
        rd("R3 disabled pin quiet", 6'h0C, 32'h0);

        // R7: last pin 120 (bank3 bit24) reaches the shared line.
        wr(6'h1C, 32'h0100_0000);
        pin(120, 1'b1);
        rd("R7 last pin recorded", 6'h0C, 32'h0100_0000);
        check("R7 shared from last bank", 32'(irq_shared), 32'h1);
        wr(6'h0C, 32'h0100_0000);

        // R10: clear write lands in the cycle the new rise on pin 6 is recorded.
        pin(6, 1'b1);
        pin(6, 1'b0);
        @(negedge clk); pins_in[6] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 6'h00; wdata = 32'h0000_0040;
        @(negedge clk); wr_en = 1'b0;
        rd("R10 set wins over clear", 6'h00, 32'h0000_0040);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule